// File: doc/BRIEF.md
# Word-Swapped Floating Comparator

This block orders two 64-bit floating operands whose storage layout swaps the
16-bit halves of each 32-bit longword and uses a sign-magnitude encoding. Each
operand arrives as a high and a low longword. A format select picks either the
narrow-exponent layout (8-bit exponent) or the wide-exponent layout (11-bit
exponent). The block reports three registered flags that describe operand 1
relative to operand 2: a "less than" flag, an "equal" flag and a flag that marks
an illegal encoding in either operand.

An execution pipeline presents a pair with `in_valid` high. One clock later the
flags are valid and `out_valid` is high. The flags hold their last values while
no new pair is presented. Internally each operand goes through its own decoder,
which classifies it and rebuilds its halves into a key whose unsigned order
matches magnitude order. A shared ordering stage then turns the two
classifications and keys into flags.

Top module: `wsfc_top`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `flag_lt`, `flag_eq` and `flag_bad` are all 0.
- R2: The flags and `out_valid` are registered. A pair presented with `in_valid`=1 at a rising edge produces its flags and `out_valid`=1 after that edge. A cycle with `in_valid`=0 drives `out_valid` to 0 and leaves all three flags unchanged.
- R3: The sign is bit 15 of the high longword. With `fmt_wide`=0 the exponent field is high bits 14:7. With `fmt_wide`=1 it is high bits 14:4.
- R4: An operand whose exponent field is 0 and whose sign is 0 counts as exactly zero, and its remaining bits are ignored.
- R5: An operand whose exponent field is 0 and whose sign is 1 is illegal. When either operand is illegal, `flag_bad`=1 and `flag_lt`=`flag_eq`=0.
- R6: If the effective signs differ (zero counts as positive), `flag_eq`=0 and `flag_lt` equals the sign of operand 1.
- R7: Magnitudes are ordered on a 64-bit key. Key bits 63:48 are high bits 15:0, 47:32 are high bits 31:16, 31:16 are low bits 15:0, and 15:0 are low bits 31:16. A zero operand has key 0.
- R8: If both keys are equal and neither operand is illegal, `flag_eq`=1 and `flag_lt`=0.
- R9: If the signs match and the keys differ, `flag_lt` = (key1 < key2) XOR sign1, and `flag_eq`=0.
- R10: `flag_lt` and `flag_eq` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new operand pair is present |
| fmt_wide | input | 1 | 0: 8-bit exponent layout, 1: 11-bit exponent layout |
| a_hi | input | 32 | Operand 1, high longword |
| a_lo | input | 32 | Operand 1, low longword |
| b_hi | input | 32 | Operand 2, high longword |
| b_lo | input | 32 | Operand 2, low longword |
| out_valid | output | 1 | Flags reflect the pair from the previous cycle |
| flag_lt | output | 1 | Operand 1 is less than operand 2 |
| flag_eq | output | 1 | Operand 1 equals operand 2 |
| flag_bad | output | 1 | An operand is an illegal encoding |

## Verification
Clocked properties check on every cycle that the less-than and equal flags are
mutually exclusive, that an illegal operand clears both, that the flags settle
one cycle after a presented pair and hold otherwise, and that differing signs,
two zeros or bit-identical legal operands give the required flags. The key
ordering can only be shown by the bench's scenarios. This covers the half-word
swap inside each longword, the XOR with the sign for negative pairs, and the way
the format select moves the exponent field so that one bit pattern is zero,
illegal or an ordinary number.

// File: rtl/wsfc_pkg.sv
package wsfc_pkg;

  localparam int HALF_W  = 16;
  localparam int LONG_W  = 2 * HALF_W;
  localparam int KEY_W   = 2 * LONG_W;
  localparam int HALVES  = KEY_W / HALF_W;
  localparam int SIGN_B  = HALF_W - 1;
  localparam int EXP_TOP = HALF_W - 2;

  typedef logic [KEY_W-1:0] key_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic bad;
  } cmp_flags_t;

  // Ordering rule on two classified operands.
  function automatic cmp_flags_t wsfc_order_fn(
      input logic s1, input logic s2,
      input key_t k1, input key_t k2,
      input logic bad);
    cmp_flags_t f;
    f = '0;
    if (bad) begin
      f.bad = 1'b1;
    end else if (s1 != s2) begin
      f.lt = s1;
    end else if (k1 == k2) begin
      f.eq = 1'b1;
    end else begin
      f.lt = (k1 < k2) ^ s1;
    end
    return f;
  endfunction

endpackage

// File: rtl/wsfc_decode.sv
module wsfc_decode
  import wsfc_pkg::*;
#(
  parameter int NARROW_EXP_W = 8,
  parameter int WIDE_EXP_W   = 11
) (
  input  logic              fmt_wide,
  input  logic [LONG_W-1:0] hi,
  input  logic [LONG_W-1:0] lo,
  output logic              eff_sign,
  output logic              is_zero,
  output logic              is_bad,
  output key_t              key
);
  localparam int NARROW_LO = EXP_TOP - NARROW_EXP_W + 1;
  localparam int WIDE_LO   = EXP_TOP - WIDE_EXP_W + 1;

  logic [KEY_W-1:0] packed_in;
  key_t             swapped;
  logic             raw_sign;
  logic             exp_zero;

  assign packed_in = {hi, lo};
  assign raw_sign  = hi[SIGN_B];

  always_comb begin
    if (fmt_wide) exp_zero = (hi[EXP_TOP:WIDE_LO] == '0);
    else          exp_zero = (hi[EXP_TOP:NARROW_LO] == '0);
  end

  // Each key half k takes input half k^1: the two halves of each longword swap.
  for (genvar k = 0; k < HALVES; k++) begin : g_swap
    assign swapped[k*HALF_W +: HALF_W] = packed_in[(k ^ 1)*HALF_W +: HALF_W];
  end

  assign is_zero  = exp_zero & ~raw_sign;
  assign is_bad   = exp_zero & raw_sign;
  assign eff_sign = raw_sign & ~exp_zero;
  assign key      = exp_zero ? '0 : swapped;

endmodule

// File: rtl/wsfc_order.sv
module wsfc_order
  import wsfc_pkg::*;
(
  input  logic       s1,
  input  logic       s2,
  input  key_t       k1,
  input  key_t       k2,
  input  logic       bad,
  output cmp_flags_t flags
);
  assign flags = wsfc_order_fn(s1, s2, k1, k2, bad);
endmodule

// File: rtl/wsfc_top.sv
module wsfc_top
  import wsfc_pkg::*;
#(
  parameter int NARROW_EXP_W = 8,
  parameter int WIDE_EXP_W   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              fmt_wide,
  input  logic [LONG_W-1:0] a_hi,
  input  logic [LONG_W-1:0] a_lo,
  input  logic [LONG_W-1:0] b_hi,
  input  logic [LONG_W-1:0] b_lo,
  output logic              out_valid,
  output logic              flag_lt,
  output logic              flag_eq,
  output logic              flag_bad
);
  localparam int NOPS = 2;

  logic [LONG_W-1:0] op_hi [NOPS];
  logic [LONG_W-1:0] op_lo [NOPS];
  logic              op_sign [NOPS];
  logic              op_zero [NOPS];
  logic              op_bad  [NOPS];
  key_t              op_key  [NOPS];
  logic              any_bad;
  cmp_flags_t        next_flags;

  assign op_hi[0] = a_hi;
  assign op_lo[0] = a_lo;
  assign op_hi[1] = b_hi;
  assign op_lo[1] = b_lo;

  for (genvar i = 0; i < NOPS; i++) begin : g_dec
    wsfc_decode #(
      .NARROW_EXP_W(NARROW_EXP_W),
      .WIDE_EXP_W  (WIDE_EXP_W)
    ) u_dec (
      .fmt_wide(fmt_wide),
      .hi      (op_hi[i]),
      .lo      (op_lo[i]),
      .eff_sign(op_sign[i]),
      .is_zero (op_zero[i]),
      .is_bad  (op_bad[i]),
      .key     (op_key[i])
    );
  end

  assign any_bad = op_bad[0] | op_bad[1];

  wsfc_order u_order (
    .s1   (op_sign[0]),
    .s2   (op_sign[1]),
    .k1   (op_key[0]),
    .k2   (op_key[1]),
    .bad  (any_bad),
    .flags(next_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag_lt   <= 1'b0;
      flag_eq   <= 1'b0;
      flag_bad  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flag_lt  <= next_flags.lt;
        flag_eq  <= next_flags.eq;
        flag_bad <= next_flags.bad;
      end
    end
  end

  // R10: the two ordering flags exclude each other
  p_lt_eq_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_lt && flag_eq));

  // R5: an illegal operand clears the ordering flags
  p_bad_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_bad |-> (!flag_lt && !flag_eq));

  // R2: one-cycle latency
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: flags hold without a new pair
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(flag_lt) && $stable(flag_eq) && $stable(flag_bad)));

  // R6: differing signs decide on operand 1's sign alone
  p_sign_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_bad && (op_sign[0] != op_sign[1]))
      |=> (flag_lt == $past(op_sign[0]) && !flag_eq && !flag_bad));

  // R4: two zeros compare equal whatever their other bits
  p_zeros_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_zero[0] && op_zero[1]) |=> (flag_eq && !flag_lt));

  // R8: bit-identical legal operands compare equal
  p_identical_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_bad && (a_hi == b_hi) && (a_lo == b_lo)) |=> flag_eq);

endmodule

// File: tb/wsfc_top_tb.sv
module wsfc_top_tb;

  typedef struct packed {
    logic        fmt;
    logic [31:0] ahi;
    logic [31:0] alo;
    logic [31:0] bhi;
    logic [31:0] blo;
    logic        lt;
    logic        eq;
    logic        bad;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h00004080, 32'h0, 32'h00004100, 32'h0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 +1 < +2
    '{1'b0, 32'h00004100, 32'h0, 32'h00004080, 32'h0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 +2 > +1
    '{1'b0, 32'h00004080, 32'h0, 32'h00004080, 32'h0, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 equal
    '{1'b0, 32'h0000C080, 32'h0, 32'h0000C100, 32'h0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 -1 > -2
    '{1'b0, 32'h0000C080, 32'h0, 32'h00004080, 32'h0, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 -1 < +1
    '{1'b0, 32'h00004080, 32'h0, 32'h0000C100, 32'h0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 +1 > -2
    '{1'b0, 32'hABCD0012, 32'h12345678, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 dirty zero == 0
    '{1'b0, 32'hABCD0012, 32'h12345678, 32'h00004080, 32'h0, 1'b1, 1'b0, 1'b0, 4'd4}, // R4
    '{1'b0, 32'hABCD0012, 32'h12345678, 32'h0000C080, 32'h0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
    '{1'b0, 32'h00008000, 32'h0, 32'h00004080, 32'h0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 op1 illegal
    '{1'b0, 32'h00004080, 32'h0, 32'h00008005, 32'h0, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 op2 illegal
    '{1'b0, 32'h00004080, 32'h00000001, 32'h00004080, 32'h00010000, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 low swap
    '{1'b0, 32'h00014080, 32'h0, 32'h000040FF, 32'h0, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 high swap
    '{1'b1, 32'h00000040, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 wide: nonzero
    '{1'b0, 32'h00000040, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd3}, // R3 narrow: zero
    '{1'b0, 32'h00008040, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 narrow: illegal
    '{1'b1, 32'h00008040, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 wide: negative
    '{1'b1, 32'h0000C010, 32'h0, 32'h0000C020, 32'h0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 wide negatives
    '{1'b0, 32'h12340005, 32'h00000001, 32'h00000070, 32'h0000FFFF, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 two zeros
    '{1'b1, 32'h00004010, 32'hDEADBEEF, 32'h00004010, 32'hDEADBEEF, 1'b0, 1'b1, 1'b0, 4'd8}  // R8 wide equal
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic fmt_wide = 1'b0;
  logic [31:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic out_valid, flag_lt, flag_eq, flag_bad;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wsfc_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_wide(fmt_wide),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .out_valid(out_valid), .flag_lt(flag_lt), .flag_eq(flag_eq), .flag_bad(flag_bad)
  );

  task automatic check4(input string tag, input logic v, input logic l,
                        input logic e, input logic b);
    checks++;
    if ({out_valid, flag_lt, flag_eq, flag_bad} !== {v, l, e, b}) begin
      failures++;
      $display("FAIL %s: got v/lt/eq/bad=%b%b%b%b expected %b%b%b%b",
               tag, out_valid, flag_lt, flag_eq, flag_bad, v, l, e, b);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: run did not end (actual hung, expected finish)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    a_hi = 32'h00004080; b_hi = 32'h00004100; in_valid = 1'b1;
    @(negedge clk);
    check4("R1 reset outputs", 1'b0, 1'b0, 1'b0, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      fmt_wide = VECS[i].fmt;
      a_hi = VECS[i].ahi; a_lo = VECS[i].alo;
      b_hi = VECS[i].bhi; b_lo = VECS[i].blo;
      in_valid = 1'b1;
      @(negedge clk);
      tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
      check4(tag, 1'b1, VECS[i].lt, VECS[i].eq, VECS[i].bad);
    end

    // R2: without in_valid the flags hold (last vector gave eq) and out_valid drops
    in_valid = 1'b0;
    fmt_wide = 1'b0;
    a_hi = 32'h00008000; b_hi = 32'h00004080;
    @(negedge clk);
    check4("R2 hold without in_valid", 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check4("R2 hold second idle cycle", 1'b0, 1'b0, 1'b1, 1'b0);

    // R2: new pair appears exactly one cycle later
    a_hi = 32'h0000C080; b_hi = 32'h00004080; in_valid = 1'b1;
    @(negedge clk);
    check4("R2 latency one cycle, R6", 1'b1, 1'b1, 1'b0, 1'b0);

    // R10 with R5: illegal after a less-than result clears lt
    a_hi = 32'h00008000;
    @(negedge clk);
    check4("R10 R5 illegal clears lt", 1'b1, 1'b0, 1'b0, 1'b1);
    in_valid = 1'b0;

    // R1: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    check4("R1 reset mid-run", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule